// File: doc/BRIEF.md
# Dual-Port Host Input Arbiter

This block joins two host byte sources, a parallel strobe port and the byte output of a serial receiver, onto one receive path. When no port holds the path, the first port to present a byte is granted it automatically. While a port holds the grant, the other port sees busy. The grant ends when the owner has presented no byte for a programmable number of clock cycles. After that the block is unowned again and either port may take it.

Every accepted byte is pushed into an internal receive FIFO. A downstream consumer drains the FIFO through a show-ahead read port. The parallel port also carries a host-initialise line. A configuration bit decides whether the block honours this line. When it is honoured, the line flushes the FIFO, drops the grant and emits a single-cycle reset pulse for the rest of the system. When it is not honoured, the line changes nothing.

Top module: `hin_arbiter`

## Requirements
- R1: After reset the block is unowned, both busy outputs and `host_reset` are low, and `rd_empty` is high.
- R2: While unowned, a byte presented by a single port (`par_strobe` or `ser_valid` high) is written to the FIFO if it is not full, and that port owns the path from the next cycle.
- R3: While unowned, if both ports present a byte in the same cycle, the parallel byte is written, the parallel port becomes owner and the serial byte is discarded.
- R4: While the parallel port owns the path, `ser_busy` is high and serial bytes are discarded. While the serial port owns it, `par_busy` is high and parallel bytes are discarded.
- R5: Accepted bytes leave through `rd_data` in arrival order. `rd_data` shows the oldest byte whenever `rd_empty` is low, and `rd_pop` removes it.
- R6: When the FIFO holds DEPTH bytes, both busy outputs are high and further bytes are discarded.
- R7: The owner loses the path after `cfg_idle_limit` consecutive cycles in which it presents no byte. A limit of 0 acts as 1.
- R8: With `cfg_prime_en` high, a cycle with `par_prime` high empties the FIFO, makes the block unowned and discards any byte offered in that cycle. `host_reset` is high for exactly one cycle, in the cycle after the first such cycle of each assertion.
- R9: With `cfg_prime_en` low, `par_prime` has no effect on the FIFO, the grant or `host_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prime_en | input | 1 | Honour the parallel host-initialise line |
| cfg_idle_limit | input | TW | Idle cycles before the grant is released |
| par_strobe | input | 1 | Parallel port byte valid for one cycle |
| par_data | input | 8 | Parallel port byte |
| par_prime | input | 1 | Parallel port host-initialise request |
| par_busy | output | 1 | Busy indication to the parallel host |
| ser_valid | input | 1 | Serial receiver byte valid for one cycle |
| ser_data | input | 8 | Serial receiver byte |
| ser_busy | output | 1 | Busy indication to the serial host |
| rd_pop | input | 1 | Consumer removes the oldest FIFO byte |
| rd_data | output | 8 | Oldest FIFO byte (show-ahead) |
| rd_empty | output | 1 | FIFO holds no byte |
| host_reset | output | 1 | Single-cycle reset pulse after an honoured prime |

## Verification
Some properties are checked on every cycle. Ownership by one port always holds the other port busy, and a full FIFO raises both busy lines and blocks writes. The single-port grant and the parallel priority on a tie take effect on the next cycle. An honoured prime leaves the FIFO empty, and `host_reset` never lasts two cycles or appears without an enabled prime before it. Other behaviour only shows up in the bench scenarios, which are compared against a reference model on every clock. These are the exact cycle on which the idle timeout releases the grant, including the zero-limit case, the arrival order of bytes through the FIFO, discarding by the losing port, and a prime that is ignored while disabled.

// File: rtl/hin_pkg.sv
package hin_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_PAR  = 2'd1,
        OWN_SER  = 2'd2
    } owner_e;

    typedef logic [7:0] hbyte_t;

    typedef struct packed {
        logic   vld;
        hbyte_t data;
    } beat_t;

    function automatic logic port_may_write(input owner_e own, input owner_e me);
        return (own == OWN_NONE) || (own == me);
    endfunction

endpackage

// File: rtl/hin_fifo.sv
module hin_fifo
    import hin_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  beat_t  wr,
    input  logic   pop,
    output hbyte_t rd_data,
    output logic   empty,
    output logic   full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    hbyte_t          mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            do_wr, do_rd;

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULLC);
    assign do_wr   = wr.vld && !full;
    assign do_rd   = pop && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr && !flush) begin
            mem[wp] <= wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) begin
                wp <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_rd) begin
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            end
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/hin_owner.sv
module hin_owner
    import hin_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          par_v,
    input  logic          ser_v,
    input  logic          full,
    input  logic [TW-1:0] idle_limit,
    output owner_e        owner,
    output logic          par_acc,
    output logic          ser_acc
);
    owner_e        own_q;
    logic [TW-1:0] idle_q;
    logic          owner_present;
    logic          idle_expired;

    assign owner = own_q;

    assign par_acc = !flush && par_v && !full && port_may_write(own_q, OWN_PAR);
    assign ser_acc = !flush && ser_v && !full && port_may_write(own_q, OWN_SER)
                     && !((own_q == OWN_NONE) && par_v);

    assign owner_present = (own_q == OWN_PAR) ? par_v : ser_v;
    assign idle_expired  = ({1'b0, idle_q} + 1'b1) >= {1'b0, idle_limit};

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            own_q  <= OWN_NONE;
            idle_q <= '0;
        end else if (own_q == OWN_NONE) begin
            idle_q <= '0;
            if (par_acc) begin
                own_q <= OWN_PAR;
            end else if (ser_acc) begin
                own_q <= OWN_SER;
            end
        end else if (owner_present) begin
            idle_q <= '0;
        end else if (idle_expired) begin
            own_q  <= OWN_NONE;
            idle_q <= '0;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end
endmodule

// File: rtl/hin_prime.sv
module hin_prime (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic prime_in,
    output logic flush,
    output logic pulse
);
    logic seen_q;

    assign flush = enable && prime_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            pulse  <= 1'b0;
        end else begin
            seen_q <= flush;
            pulse  <= flush && !seen_q;
        end
    end
endmodule

// File: rtl/hin_arbiter.sv
module hin_arbiter
    import hin_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_prime_en,
    input  logic [TW-1:0] cfg_idle_limit,
    input  logic          par_strobe,
    input  logic [7:0]    par_data,
    input  logic          par_prime,
    output logic          par_busy,
    input  logic          ser_valid,
    input  logic [7:0]    ser_data,
    output logic          ser_busy,
    input  logic          rd_pop,
    output logic [7:0]    rd_data,
    output logic          rd_empty,
    output logic          host_reset
);
    owner_e own_q;
    logic   fifo_full;
    logic   flush;
    logic   par_acc, ser_acc;
    logic   wr_en;
    beat_t  wbeat;

    hin_prime u_prime (
        .clk      (clk),
        .rst      (rst),
        .enable   (cfg_prime_en),
        .prime_in (par_prime),
        .flush    (flush),
        .pulse    (host_reset)
    );

    hin_owner #(.TW(TW)) u_owner (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .par_v      (par_strobe),
        .ser_v      (ser_valid),
        .full       (fifo_full),
        .idle_limit (cfg_idle_limit),
        .owner      (own_q),
        .par_acc    (par_acc),
        .ser_acc    (ser_acc)
    );

    assign wr_en      = par_acc || ser_acc;
    assign wbeat.vld  = wr_en;
    assign wbeat.data = par_acc ? par_data : ser_data;

    hin_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr      (wbeat),
        .pop     (rd_pop),
        .rd_data (rd_data),
        .empty   (rd_empty),
        .full    (fifo_full)
    );

    assign par_busy = (own_q == OWN_SER) || fifo_full;
    assign ser_busy = (own_q == OWN_PAR) || fifo_full;
endmodule

// File: rtl/hin_arbiter_chk.sv
module hin_arbiter_chk
    import hin_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   cfg_prime_en,
    input logic   par_prime,
    input logic   par_strobe,
    input logic   ser_valid,
    input logic   par_busy,
    input logic   ser_busy,
    input logic   rd_empty,
    input logic   host_reset,
    input owner_e owner,
    input logic   fifo_full,
    input logic   wr_en
);
    logic prime_on;
    assign prime_on = cfg_prime_en && par_prime;

    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_NONE && ser_valid && !par_strobe && !fifo_full && !prime_on)
        |=> (owner == OWN_SER));

    a_r3_parallel_wins: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_NONE && par_strobe && ser_valid && !fifo_full && !prime_on)
        |=> (owner == OWN_PAR));

    a_r4_par_owner_blocks: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_PAR) |-> ser_busy);

    a_r4_ser_owner_blocks: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_SER) |-> par_busy);

    a_r6_full_busy: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> (par_busy && ser_busy && !wr_en));

    a_r8_flush_empty: assert property (@(posedge clk) disable iff (rst)
        prime_on |=> (rd_empty && owner == OWN_NONE));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        host_reset |=> !host_reset);

    a_r9_pulse_needs_enable: assert property (@(posedge clk) disable iff (rst)
        host_reset |-> $past(prime_on));
endmodule

bind hin_arbiter hin_arbiter_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_prime_en (cfg_prime_en),
    .par_prime    (par_prime),
    .par_strobe   (par_strobe),
    .ser_valid    (ser_valid),
    .par_busy     (par_busy),
    .ser_busy     (ser_busy),
    .rd_empty     (rd_empty),
    .host_reset   (host_reset),
    .owner        (own_q),
    .fifo_full    (fifo_full),
    .wr_en        (wr_en)
);

// File: tb/sim_hin_arbiter.sv
module sim_hin_arbiter;
    localparam int DEPTH = 8;
    localparam int TW    = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_prime_en = 1'b0;
    logic [TW-1:0] cfg_idle_limit = 16'd5;
    logic          par_strobe = 1'b0;
    logic [7:0]    par_data = '0;
    logic          par_prime = 1'b0;
    logic          ser_valid = 1'b0;
    logic [7:0]    ser_data = '0;
    logic          rd_pop = 1'b0;
    logic          par_busy, ser_busy, rd_empty, host_reset;
    logic [7:0]    rd_data;

    always #5 clk = ~clk;

    hin_arbiter #(.DEPTH(DEPTH), .TW(TW)) u0 (
        .clk(clk), .rst(rst), .cfg_prime_en(cfg_prime_en), .cfg_idle_limit(cfg_idle_limit),
        .par_strobe(par_strobe), .par_data(par_data), .par_prime(par_prime), .par_busy(par_busy),
        .ser_valid(ser_valid), .ser_data(ser_data), .ser_busy(ser_busy),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_empty(rd_empty), .host_reset(host_reset)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model: owner 0 none, 1 parallel, 2 serial
    int         m_own  = 0;
    int         m_idle = 0;
    logic [7:0] m_q[$];
    bit         m_seen = 0;
    bit         m_hr   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        bit mfull;
        mfull = (m_q.size() == DEPTH);
        chk("R4 par_busy", 32'(par_busy), 32'(m_own == 2 || mfull));
        chk("R4 ser_busy", 32'(ser_busy), 32'(m_own == 1 || mfull));
        chk("R5 rd_empty", 32'(rd_empty), 32'(m_q.size() == 0));
        if (m_q.size() != 0) chk("R5 rd_data", 32'(rd_data), 32'(m_q[0]));
        chk("R8 host_reset", 32'(host_reset), 32'(m_hr));
    endtask

    task automatic cyc();
        bit mfull, pact, pacc, sacc, present;
        int lim, n_own, n_idle;
        mfull = (m_q.size() == DEPTH);
        pact  = cfg_prime_en && par_prime;
        pacc  = !pact && par_strobe && !mfull && (m_own == 0 || m_own == 1);
        sacc  = !pact && ser_valid && !mfull && (m_own == 2 || (m_own == 0 && !par_strobe));
        lim   = (cfg_idle_limit == 0) ? 1 : int'(cfg_idle_limit);
        n_own = m_own; n_idle = m_idle;
        if (pact) begin
            n_own = 0; n_idle = 0;
        end else if (m_own == 0) begin
            n_idle = 0;
            if (pacc) n_own = 1; else if (sacc) n_own = 2;
        end else begin
            present = (m_own == 1) ? par_strobe : ser_valid;
            if (present) n_idle = 0;
            else if (m_idle + 1 >= lim) begin n_own = 0; n_idle = 0; end
            else n_idle = m_idle + 1;
        end
        @(posedge clk);
        @(negedge clk);
        if (pact) m_q.delete();
        else begin
            if (rd_pop && m_q.size() != 0) void'(m_q.pop_front());
            if (pacc) m_q.push_back(par_data);
            else if (sacc) m_q.push_back(ser_data);
        end
        m_hr   = pact && !m_seen;
        m_seen = pact;
        m_own  = n_own;
        m_idle = n_idle;
        compare();
    endtask

    task automatic send(input bit ps, input logic [7:0] pd, input bit sv, input logic [7:0] sd);
        par_strobe = ps; par_data = pd; ser_valid = sv; ser_data = sd;
        cyc();
        par_strobe = 0; ser_valid = 0;
    endtask

    task automatic pop_expect(input string tag, input logic [7:0] exp);
        chk(tag, 32'(rd_data), 32'(exp));
        rd_pop = 1; cyc(); rd_pop = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        m_own = 0; m_idle = 0; m_q.delete(); m_seen = 0; m_hr = 0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 par_busy", 32'(par_busy), 0);
        chk("R1 ser_busy", 32'(ser_busy), 0);
        chk("R1 rd_empty", 32'(rd_empty), 1);
        chk("R1 host_reset", 32'(host_reset), 0);

        // R2 serial arrives first and takes the path; R4 parallel byte dropped
        send(0, 8'h00, 1, 8'h11);
        chk("R2 ser granted par_busy", 32'(par_busy), 1);
        send(0, 8'h00, 1, 8'h22);
        send(0, 8'h00, 1, 8'h33);
        send(1, 8'hEE, 0, 8'h00);        // idle cycle 1 for the serial owner
        repeat (3) cyc();                // idle cycles 2..4
        chk("R7 still owned", 32'(par_busy), 1);
        cyc();                           // idle cycle 5 -> released
        chk("R7 released", 32'(par_busy), 0);
        pop_expect("R5 order 0", 8'h11);
        pop_expect("R5 order 1", 8'h22);
        pop_expect("R4 order 2 no par byte", 8'h33);
        chk("R4 dropped byte absent", 32'(rd_empty), 1);

        // R3 tie goes to the parallel port
        send(1, 8'hA5, 1, 8'h5A);
        chk("R3 ser_busy", 32'(ser_busy), 1);
        pop_expect("R3 parallel byte", 8'hA5);
        chk("R3 serial byte discarded", 32'(rd_empty), 1);
        repeat (6) cyc();

        // R6 fill beyond depth
        par_strobe = 1;
        for (int i = 0; i < DEPTH + 2; i++) begin
            par_data = 8'(8'h40 + i);
            cyc();
        end
        par_strobe = 0;
        chk("R6 par_busy full", 32'(par_busy), 1);
        chk("R6 ser_busy full", 32'(ser_busy), 1);
        for (int i = 0; i < DEPTH; i++) pop_expect("R6 kept bytes", 8'(8'h40 + i));
        chk("R6 extra bytes dropped", 32'(rd_empty), 1);
        repeat (6) cyc();

        // R9 prime ignored when disabled
        cfg_prime_en = 0;
        send(0, 8'h00, 1, 8'h77);
        par_prime = 1; cyc(); par_prime = 0; cyc();
        chk("R9 fifo kept", 32'(rd_empty), 0);
        chk("R9 no pulse", 32'(host_reset), 0);
        chk("R9 grant kept", 32'(par_busy), 1);

        // R8 prime honoured
        cfg_prime_en = 1;
        par_prime = 1; par_strobe = 1; par_data = 8'h99;
        cyc();
        par_strobe = 0;
        chk("R8 pulse", 32'(host_reset), 1);
        chk("R8 flushed", 32'(rd_empty), 1);
        chk("R8 released", 32'(par_busy), 0);
        cyc();
        chk("R8 pulse once", 32'(host_reset), 0);
        par_prime = 0; cyc();

        // R7 zero limit acts as one
        cfg_idle_limit = 0;
        send(1, 8'h12, 0, 8'h00);
        chk("R7 zero limit owned", 32'(ser_busy), 1);
        cyc();
        chk("R7 zero limit released", 32'(ser_busy), 0);
        rd_pop = 1; cyc(); rd_pop = 0;

        // mixed traffic against the model
        cfg_idle_limit = 3;
        for (int i = 0; i < 3000; i++) begin
            par_strobe   = ($urandom_range(0, 2) == 0);
            par_data     = 8'($urandom);
            ser_valid    = ($urandom_range(0, 2) == 0);
            ser_data     = 8'($urandom);
            rd_pop       = ($urandom_range(0, 3) == 0);
            par_prime    = ($urandom_range(0, 60) == 0);
            cfg_prime_en = ($urandom_range(0, 1) == 0);
            cyc();
        end
        par_strobe = 0; ser_valid = 0; rd_pop = 0; par_prime = 0;

        do_reset();
        chk("R1 reset again", 32'(rd_empty), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule